// File: doc/BRIEF.md
# Spare Row and Column Allocation Engine

This block works out how a memory's spare rows and spare columns should be spent so that every defective cell found by a self-test is covered. While the test runs, a comparator that reports addresses delivers failing cells one per cycle as (row, column) pairs. The block keeps each distinct pair in a small log of fixed depth. When the test signals that capture is over and a start pulse arrives, the engine walks the log three times. Each visit makes at most one allocation. The engine then reports a repair solution or declares the memory unrepairable.

The three walks run in a fixed order. The first handles forced columns: a column whose distinct failing rows outnumber the free spare rows can only be covered by a spare column. The second handles clustered rows: a row holding two or more uncovered failures gets a spare row while spare rows remain. The third covers each remaining isolated failure, with a spare column first and a spare row when no column is left. A failure whose row or column is already replaced uses no new spare. The solution appears on per-spare valid bits and replaced-address fields, which the fuse or soft-repair logic downstream can read directly.

Top module: `spare_alloc_engine`

## Requirements
- R1: After reset, or after a one-cycle `clear` pulse, all spare valid bits are 0 and `done`, `repairable` and `unrepairable` are 0.
- R2: While capture is open, each distinct (row, column) pair offered with `fail_valid` takes one log slot. A pair already in the log takes no slot. Pairs offered after `test_done` has been seen are ignored.
- R3: A new distinct pair that arrives when all LOG_DEPTH slots are full raises `unrepairable` from the next cycle, before any start. A later start then ends the run with no spare allocated.
- R4: `start` is acted on only when it arrives in a cycle after the one in which `test_done` was seen. An earlier start has no effect.
- R5: Forced-column pass: an uncovered failure whose column holds more uncovered distinct failing rows than there are free spare rows gets a spare column before any row is assigned.
- R6: Cluster pass: an uncovered failure whose row holds two or more uncovered failures gets a spare row while one is free. If no spare row is free and that row holds more uncovered failures than there are free spare columns, the run ends unrepairable at that point, and no further spare columns are consumed.
- R7: Leftover pass: each failure still uncovered gets a spare column if one is free, otherwise a spare row.
- R8: A failure whose row matches an allocated spare row, or whose column matches an allocated spare column, consumes no spare.
- R9: If an uncovered failure has no spare left to cover it, `done` and `unrepairable` rise and `repairable` stays 0. `repairable` and `unrepairable` are never high together.
- R10: Spares of each kind are handed out from slot 0 upward. Slot k's replaced address sits at bits [k*W +: W] of its address output, where W is the row or column address width.
- R11: `done` rises no more than 3*LOG_DEPTH+1 cycles after the start cycle and holds until clear. With `done` high, `repairable` is high exactly when `unrepairable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | One-cycle synchronous clear of log, spares and status |
| fail_valid | input | 1 | A failing cell address is offered this cycle |
| fail_row | input | ROW_W | Row of the failing cell |
| fail_col | input | COL_W | Column of the failing cell |
| test_done | input | 1 | Failure capture is complete |
| start | input | 1 | Begin allocation |
| done | output | 1 | Allocation finished |
| repairable | output | 1 | Finished and all failures covered |
| unrepairable | output | 1 | Failures exceed spares or the log overflowed |
| sr_valid | output | N_SR | Spare row k is allocated |
| sr_addr | output | N_SR*ROW_W | Row replaced by each spare row |
| sc_valid | output | N_SC | Spare column k is allocated |
| sc_addr | output | N_SC*COL_W | Column replaced by each spare column |

## Verification
The bench targets cases where a plain greedy cover gives a different answer from the three-pass order. In the first, a column with three failing rows is mixed with isolated cells: a design without the forced-column pass spends both columns on the isolated cells and wrongly reports unrepairable. In the second, a three-failure row arrives after both spare rows are gone: a design without the row must-repair cutoff spends spare columns before failing, which shows up on the column valid bits. A third scenario has a failure inside an already-repaired row, which exposes any allocator that does not absorb covered failures. The last group covers the log boundary (sixteen distinct entries with duplicates must not overflow, a seventeenth must), a start that arrives too early, and fails offered after capture closes.

// File: rtl/spare_alloc_pkg.sv
package spare_alloc_pkg;

    typedef enum logic [2:0] {
        PH_CAPTURE,
        PH_COLMUST,
        PH_ROWMULTI,
        PH_LEFTOVER,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ROW,
        ACT_COL,
        ACT_FAIL
    } act_e;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_COLMUST:  return PH_ROWMULTI;
            PH_ROWMULTI: return PH_LEFTOVER;
            default:     return PH_DONE;
        endcase
    endfunction

endpackage

// File: rtl/sa_fail_log.sv
module sa_fail_log
    import spare_alloc_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        cap_en,
    input  logic                        in_valid,
    input  logic [ROW_W-1:0]            in_row,
    input  logic [COL_W-1:0]            in_col,
    output logic [DEPTH-1:0]            ent_vld,
    output logic [DEPTH-1:0][ROW_W-1:0] ent_row,
    output logic [DEPTH-1:0][COL_W-1:0] ent_col,
    output logic                        ovf
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [FW-1:0] fill;
    logic          hit;
    logic          take;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ent_vld[k] && ent_row[k] == in_row && ent_col[k] == in_col)
                hit = 1'b1;
        end
    end

    assign take = cap_en && in_valid && !hit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ent_vld <= '0;
            ent_row <= '0;
            ent_col <= '0;
            fill    <= '0;
            ovf     <= 1'b0;
        end else if (take) begin
            if (fill == FW'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (fill == FW'(k)) begin
                        ent_vld[k] <= 1'b1;
                        ent_row[k] <= in_row;
                        ent_col[k] <= in_col;
                    end
                end
                fill <= fill + FW'(1);
            end
        end
    end

    // R3: occupancy never exceeds the log depth
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));

    // R3: overflow is sticky until clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clear) |=> ovf);

    // R3: overflow only appears once every slot is occupied
    p_ovf_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (&ent_vld));

endmodule

// File: rtl/sa_spare_bank.sv
module sa_spare_bank
    import spare_alloc_pkg::*;
#(
    parameter int AW = 10,
    parameter int N  = 2,
    localparam int FW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 alloc,
    input  logic [AW-1:0]        alloc_addr,
    output logic [N-1:0]         vld,
    output logic [N-1:0][AW-1:0] addr,
    output logic [FW-1:0]        free_cnt
);
    logic [N:0] below;

    assign below = {vld, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld  <= '0;
            addr <= '0;
        end else if (alloc) begin
            for (int k = 0; k < N; k++) begin
                if (!vld[k] && below[k]) begin
                    vld[k]  <= 1'b1;
                    addr[k] <= alloc_addr;
                end
            end
        end
    end

    always_comb free_cnt = FW'(N) - FW'($countones(vld));

    // R10: slots fill from 0 upward, so valid bits stay a thermometer code
    p_thermo_r10: assert property (@(posedge clk) disable iff (rst)
        (vld & (vld + N'(1))) == '0);

    // R10: each allocation adds exactly one spare
    p_grow_one_r10: assert property (@(posedge clk) disable iff (rst)
        (alloc && !clear) |=> $countones(vld) == $past($countones(vld)) + 1);

    // R9: the controller never asks for a spare that does not exist
    p_room_r9: assert property (@(posedge clk) disable iff (rst)
        alloc |-> free_cnt != '0);

endmodule

// File: rtl/sa_alloc_ctrl.sv
module sa_alloc_ctrl
    import spare_alloc_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8,
    parameter int N_SR  = 2,
    parameter int N_SC  = 2,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         start,
    input  logic                         test_done,
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][ROW_W-1:0]  ent_row,
    input  logic [DEPTH-1:0][COL_W-1:0]  ent_col,
    input  logic                         log_ovf,
    input  logic [N_SR-1:0]              sr_vld,
    input  logic [N_SR-1:0][ROW_W-1:0]   sr_addr,
    input  logic [$clog2(N_SR+1)-1:0]    sr_free,
    input  logic [N_SC-1:0]              sc_vld,
    input  logic [N_SC-1:0][COL_W-1:0]   sc_addr,
    input  logic [$clog2(N_SC+1)-1:0]    sc_free,
    output logic                         cap_en,
    output logic                         row_alloc,
    output logic [ROW_W-1:0]             row_addr,
    output logic                         col_alloc,
    output logic [COL_W-1:0]             col_addr,
    output logic                         done,
    output logic                         repairable,
    output logic                         unrepairable
);
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(max3(DEPTH, N_SR, N_SC) + 1);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    phase_e          ph;
    logic [IW-1:0]   idx;
    logic            cap_done;
    logic            unrep_r;
    act_e            act;

    logic [DEPTH-1:0] covered;
    logic [DEPTH-1:0] unc;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             cur_live;
    logic [CW-1:0]    rowcnt, colcnt, sr_free_x, sc_free_x;

    // Coverage of every logged failure by the spares allocated so far
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            covered[k] = 1'b0;
            for (int j = 0; j < N_SR; j++)
                if (sr_vld[j] && sr_addr[j] == ent_row[k]) covered[k] = 1'b1;
            for (int j = 0; j < N_SC; j++)
                if (sc_vld[j] && sc_addr[j] == ent_col[k]) covered[k] = 1'b1;
        end
        unc = ent_vld & ~covered;
    end

    assign cur_row   = ent_row[idx];
    assign cur_col   = ent_col[idx];
    assign cur_live  = unc[idx];
    assign sr_free_x = CW'(sr_free);
    assign sc_free_x = CW'(sc_free);

    // Uncovered failures sharing the visited entry's row and column
    always_comb begin
        rowcnt = '0;
        colcnt = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (unc[k] && ent_row[k] == cur_row) rowcnt = rowcnt + CW'(1);
            if (unc[k] && ent_col[k] == cur_col) colcnt = colcnt + CW'(1);
        end
    end

    // Decision for the visited entry in the current pass
    always_comb begin
        act = ACT_NONE;
        if (cur_live) begin
            case (ph)
                PH_COLMUST: begin
                    if (colcnt > sr_free_x)
                        act = (sc_free_x != '0) ? ACT_COL : ACT_FAIL;
                end
                PH_ROWMULTI: begin
                    if (rowcnt >= CW'(2)) begin
                        if (sr_free_x != '0)        act = ACT_ROW;
                        else if (rowcnt > sc_free_x) act = ACT_FAIL;
                    end
                end
                PH_LEFTOVER: begin
                    if (sc_free_x != '0)      act = ACT_COL;
                    else if (sr_free_x != '0) act = ACT_ROW;
                    else                      act = ACT_FAIL;
                end
                default: act = ACT_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph       <= PH_CAPTURE;
            idx      <= '0;
            cap_done <= 1'b0;
            unrep_r  <= 1'b0;
        end else begin
            if (log_ovf) unrep_r <= 1'b1;
            case (ph)
                PH_CAPTURE: begin
                    if (test_done) cap_done <= 1'b1;
                    if (start && cap_done) begin
                        ph  <= log_ovf ? PH_DONE : PH_COLMUST;
                        idx <= '0;
                    end
                end
                PH_COLMUST, PH_ROWMULTI, PH_LEFTOVER: begin
                    if (act == ACT_FAIL) begin
                        unrep_r <= 1'b1;
                        ph      <= PH_DONE;
                    end else if (idx == LAST) begin
                        ph  <= next_phase(ph);
                        idx <= '0;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: ph <= PH_DONE;
            endcase
        end
    end

    assign cap_en       = (ph == PH_CAPTURE) && !cap_done;
    assign row_alloc    = (act == ACT_ROW);
    assign col_alloc    = (act == ACT_COL);
    assign row_addr     = cur_row;
    assign col_addr     = cur_col;
    assign done         = (ph == PH_DONE);
    assign unrepairable = unrep_r || log_ovf;
    assign repairable   = done && !unrepairable;

    // R9: the two verdicts never coexist
    p_verdict_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(repairable && unrepairable));

    // R9: an unrepairable verdict holds until clear
    p_unrep_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (unrepairable && !clear) |=> unrepairable);

    // R11: completion holds until clear
    p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> done);

    // R4: no pass begins while capture is still open
    p_early_start_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CAPTURE && !cap_done) |=> (ph == PH_CAPTURE));

endmodule

// File: rtl/spare_alloc_engine.sv
module spare_alloc_engine
    import spare_alloc_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 8,
    parameter int N_SR      = 2,
    parameter int N_SC      = 2,
    parameter int LOG_DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    fail_valid,
    input  logic [ROW_W-1:0]        fail_row,
    input  logic [COL_W-1:0]        fail_col,
    input  logic                    test_done,
    input  logic                    start,
    output logic                    done,
    output logic                    repairable,
    output logic                    unrepairable,
    output logic [N_SR-1:0]         sr_valid,
    output logic [N_SR*ROW_W-1:0]   sr_addr,
    output logic [N_SC-1:0]         sc_valid,
    output logic [N_SC*COL_W-1:0]   sc_addr
);
    localparam int SFW = $clog2(N_SR + 1);
    localparam int CFW = $clog2(N_SC + 1);

    logic                            cap_en, log_ovf;
    logic [LOG_DEPTH-1:0]            ent_vld;
    logic [LOG_DEPTH-1:0][ROW_W-1:0] ent_row;
    logic [LOG_DEPTH-1:0][COL_W-1:0] ent_col;
    logic                            row_alloc, col_alloc;
    logic [ROW_W-1:0]                row_addr;
    logic [COL_W-1:0]                col_addr;
    logic [N_SR-1:0][ROW_W-1:0]      sr_arr;
    logic [N_SC-1:0][COL_W-1:0]      sc_arr;
    logic [SFW-1:0]                  sr_free;
    logic [CFW-1:0]                  sc_free;

    sa_fail_log #(.ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(LOG_DEPTH)) log_i (
        .clk(clk), .rst(rst), .clear(clear), .cap_en(cap_en),
        .in_valid(fail_valid), .in_row(fail_row), .in_col(fail_col),
        .ent_vld(ent_vld), .ent_row(ent_row), .ent_col(ent_col), .ovf(log_ovf)
    );

    sa_spare_bank #(.AW(ROW_W), .N(N_SR)) rows_i (
        .clk(clk), .rst(rst), .clear(clear), .alloc(row_alloc),
        .alloc_addr(row_addr), .vld(sr_valid), .addr(sr_arr), .free_cnt(sr_free)
    );

    sa_spare_bank #(.AW(COL_W), .N(N_SC)) cols_i (
        .clk(clk), .rst(rst), .clear(clear), .alloc(col_alloc),
        .alloc_addr(col_addr), .vld(sc_valid), .addr(sc_arr), .free_cnt(sc_free)
    );

    sa_alloc_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .N_SR(N_SR), .N_SC(N_SC), .DEPTH(LOG_DEPTH)
    ) ctrl_i (
        .clk(clk), .rst(rst), .clear(clear), .start(start), .test_done(test_done),
        .ent_vld(ent_vld), .ent_row(ent_row), .ent_col(ent_col), .log_ovf(log_ovf),
        .sr_vld(sr_valid), .sr_addr(sr_arr), .sr_free(sr_free),
        .sc_vld(sc_valid), .sc_addr(sc_arr), .sc_free(sc_free),
        .cap_en(cap_en), .row_alloc(row_alloc), .row_addr(row_addr),
        .col_alloc(col_alloc), .col_addr(col_addr), .done(done),
        .repairable(repairable), .unrepairable(unrepairable)
    );

    assign sr_addr = sr_arr;
    assign sc_addr = sc_arr;

endmodule

// File: tb/spare_alloc_engine_tb_top.sv
module spare_alloc_engine_tb_top;
    localparam int ROW_W = 10;
    localparam int COL_W = 8;
    localparam int N_SR  = 2;
    localparam int N_SC  = 2;
    localparam int DEPTH = 16;
    localparam int LAT_MAX = 3 * DEPTH + 1;

    localparam int NS = 7;
    localparam int NF = 8;
    localparam int V_N[NS] = '{4, 0, 4, 5, 6, 8, 7};
    localparam int V_R[NS][NF] = '{
        '{137, 137, 137, 900, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{5, 5, 5, 6, 0, 0, 0, 0},
        '{10, 11, 1, 2, 3, 0, 0, 0},
        '{20, 20, 21, 21, 22, 22, 0, 0},
        '{30, 30, 31, 31, 32, 32, 33, 33},
        '{40, 40, 41, 41, 42, 42, 42, 0}};
    localparam int V_C[NS][NF] = '{
        '{3, 40, 77, 12, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{9, 9, 20, 20, 0, 0, 0, 0},
        '{1, 2, 7, 7, 7, 0, 0, 0},
        '{1, 2, 3, 4, 5, 6, 0, 0},
        '{1, 2, 3, 4, 5, 6, 7, 8},
        '{1, 2, 3, 4, 5, 6, 7, 0}};
    localparam int E_UN[NS]     = '{0, 0, 0, 0, 0, 1, 1};
    localparam int E_SRV[NS]    = '{1, 0, 1, 1, 3, 3, 3};
    localparam int E_SR[NS][2]  = '{'{137, 0}, '{0, 0}, '{5, 0}, '{11, 0}, '{20, 21}, '{30, 31}, '{40, 41}};
    localparam int E_SCV[NS]    = '{1, 0, 1, 3, 3, 3, 0};
    localparam int E_SC[NS][2]  = '{'{12, 0}, '{0, 0}, '{20, 0}, '{7, 1}, '{5, 6}, '{5, 6}, '{0, 0}};

    logic clk = 1'b0;
    logic rst, clear, fail_valid, test_done, start;
    logic [ROW_W-1:0] fail_row;
    logic [COL_W-1:0] fail_col;
    logic done, repairable, unrepairable;
    logic [N_SR-1:0] sr_valid;
    logic [N_SR*ROW_W-1:0] sr_addr;
    logic [N_SC-1:0] sc_valid;
    logic [N_SC*COL_W-1:0] sc_addr;

    int checks = 0;
    int errors = 0;

    always #10ns clk = ~clk;

    spare_alloc_engine #(
        .ROW_W(ROW_W), .COL_W(COL_W), .N_SR(N_SR), .N_SC(N_SC), .LOG_DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst(rst), .clear(clear), .fail_valid(fail_valid),
        .fail_row(fail_row), .fail_col(fail_col), .test_done(test_done),
        .start(start), .done(done), .repairable(repairable),
        .unrepairable(unrepairable), .sr_valid(sr_valid), .sr_addr(sr_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr)
    );

    function automatic string scen_req(int s);
        case (s)
            0: return "R6 R7";
            1: return "R11";
            2: return "R8";
            3: return "R5";
            4: return "R10";
            5: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        tick();
        clear = 1'b0;
    endtask

    task automatic send(input int r, input int c);
        fail_valid = 1'b1;
        fail_row   = ROW_W'(r);
        fail_col   = COL_W'(c);
        tick();
        fail_valid = 1'b0;
    endtask

    task automatic close_capture();
        test_done = 1'b1;
        tick();
        test_done = 1'b0;
    endtask

    task automatic kick(output int lat);
        start = 1'b1;
        tick();
        start = 1'b0;
        lat = 1;
        while (!done && lat < 4 * DEPTH) begin
            tick();
            lat++;
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, "done", done, 0);
        chk(req, "repairable", repairable, 0);
        chk(req, "unrepairable", unrepairable, 0);
        chk(req, "sr_valid", sr_valid, 0);
        chk(req, "sc_valid", sc_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        rst = 1'b1; clear = 1'b0; fail_valid = 1'b0; test_done = 1'b0; start = 1'b0;
        fail_row = '0; fail_col = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        check_idle("R1");

        // Table-driven scenarios
        for (int s = 0; s < NS; s++) begin
            do_clear();
            for (int i = 0; i < V_N[s]; i++) send(V_R[s][i], V_C[s][i]);
            close_capture();
            kick(lat);
            chk("R11", $sformatf("scenario %0d done", s), done, 1);
            chk("R11", $sformatf("scenario %0d latency bound", s), (lat <= LAT_MAX), 1);
            chk(scen_req(s), $sformatf("scenario %0d unrepairable", s), unrepairable, E_UN[s]);
            chk("R11", $sformatf("scenario %0d repairable", s), repairable, 1 - E_UN[s]);
            chk(scen_req(s), $sformatf("scenario %0d sr_valid", s), sr_valid, E_SRV[s]);
            chk(scen_req(s), $sformatf("scenario %0d sc_valid", s), sc_valid, E_SCV[s]);
            for (int k = 0; k < 2; k++) begin
                if (E_SRV[s][k])
                    chk("R10", $sformatf("scenario %0d spare row %0d", s, k),
                        sr_addr[k*ROW_W +: ROW_W], E_SR[s][k]);
                if (E_SCV[s][k])
                    chk("R10", $sformatf("scenario %0d spare col %0d", s, k),
                        sc_addr[k*COL_W +: COL_W], E_SC[s][k]);
            end
        end

        // R11: a second start while finished changes nothing
        start = 1'b1; tick(); start = 1'b0;
        repeat (5) tick();
        chk("R11", "done held after extra start", done, 1);
        chk("R11", "sc_valid after extra start", sc_valid, 0);

        // R1: clear wipes the previous verdict and spares
        do_clear();
        check_idle("R1");

        // R3: overflow of the failure log
        for (int i = 0; i < DEPTH; i++) send(i, i);
        chk("R3", "no overflow at exactly full", unrepairable, 0);
        send(DEPTH, DEPTH);
        chk("R3", "overflow flagged before start", unrepairable, 1);
        chk("R3", "done low before start", done, 0);
        close_capture();
        kick(lat);
        chk("R3", "done after overflow", done, 1);
        chk("R3", "repairable after overflow", repairable, 0);
        chk("R3", "no spare rows after overflow", sr_valid, 0);
        chk("R3", "no spare cols after overflow", sc_valid, 0);

        // R2: duplicates take no slot
        do_clear();
        for (int i = 0; i < DEPTH; i++) send(i + 100, i);
        for (int i = 0; i < 4; i++) send(i + 100, i);
        chk("R2", "duplicates do not overflow", unrepairable, 0);

        // R4: start before capture completes is ignored
        do_clear();
        send(7, 7);
        start = 1'b1; tick(); start = 1'b0;
        repeat (LAT_MAX + 5) tick();
        chk("R4", "early start ignored", done, 0);
        chk("R4", "no spare after early start", sc_valid, 0);
        close_capture();
        kick(lat);
        chk("R4", "start after capture runs", done, 1);
        chk("R4", "lone fail covered by column", sc_addr[COL_W-1:0], 7);

        // R2: fails after test_done are ignored
        do_clear();
        send(3, 3);
        close_capture();
        send(4, 4);
        send(4, 5);
        kick(lat);
        chk("R2", "late fails ignored sr_valid", sr_valid, 0);
        chk("R2", "late fails ignored sc_valid", sc_valid, 1);
        chk("R2", "captured fail column", sc_addr[COL_W-1:0], 3);
        chk("R2", "repairable", repairable, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule